// File: doc/BRIEF.md
# Wide Message Flit Serializer

This block takes one wide message at a time and sends it over a narrow link as a packet of flits. A message carries a packet identifier, a source address, a destination address, a payload-flit count and up to `MAX_PAY` payload words of `FLIT_W` bits each. Messages vary in length, so a short request takes only a few link cycles and a long reply takes many.

On acceptance the message is copied into one internal message register, and the input side stays closed until the packet has fully left. The first flit on the link is a header that carries the addressing fields. The payload words follow as body flits, and the last one is marked as the tail. Two sideband bits mark each flit as head, tail or neither. The link uses a ready/valid handshake, so the receiver can stall any flit for as long as it needs to.

Top module: `wide_msg_serializer`

## Requirements
- R1: While reset is held, and on the first cycle after it, `flit_valid` is 0 and `msg_ready` is 1.
- R2: A message is taken on a clock edge where both `msg_valid` and `msg_ready` are 1. `msg_ready` is 0 from the next cycle until the edge on which the tail flit is accepted, and it is 1 again on the cycle after that edge.
- R3: The first flit after acceptance has `flit_head`=1 and `flit_tail`=0. Its data holds the destination in bits [ADDR_W-1:0], the source in [2*ADDR_W-1:ADDR_W], the identifier in the next ID_W bits and the effective payload count in the next LEN_W bits. All higher bits are 0.
- R4: Payload flits follow the header in order. Flit k (k = 1..count) carries `msg_payload[(k-1)*FLIT_W +: FLIT_W]`.
- R5: A packet has exactly count+1 flits. Only the last one has `flit_tail`=1, and the flits between the header and the tail have both type bits at 0.
- R6: `flit_head` and `flit_tail` are never both 1 while `flit_valid` is 1.
- R7: While `flit_valid` is 1 and `flit_ready` is 0, the data and both type bits keep their values on the next cycle, and the flit does not advance.
- R8: A message with one payload flit goes out as a header followed directly by a tail.
- R9: A count of 0 is treated as 1, and a count above `MAX_PAY` is treated as `MAX_PAY`. The header reports the effective count.
- R10: While a packet is in flight, `msg_valid` and all message fields are ignored. The flits keep their captured values, and no second packet starts unless a new handshake occurs.
- R11: `flit_valid` stays 1 on every cycle from the cycle after acceptance until the tail is accepted, so there are no gaps within a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A message is offered |
| msg_ready | output | 1 | The serializer can take a message |
| msg_id | input | ID_W | Packet identifier |
| msg_src | input | ADDR_W | Source address |
| msg_dst | input | ADDR_W | Destination address |
| msg_len | input | LEN_W | Number of payload flits requested |
| msg_payload | input | MAX_PAY*FLIT_W | Payload words, word 0 in the low bits |
| flit_valid | output | 1 | A flit is on the link |
| flit_ready | input | 1 | The receiver accepts the flit |
| flit_data | output | FLIT_W | Flit contents |
| flit_head | output | 1 | The flit is a header |
| flit_tail | output | 1 | The flit ends the packet |

## Verification
The assertions check the cycle-level rules on every cycle:
- the two type bits are exclusive;
- flits hold steady while stalled;
- the input side stays closed during a packet and reopens after the tail;
- a header follows each acceptance, and no second header appears within a packet;
- `flit_valid` has no gaps within a packet.

Only the bench scenarios can show that the data is correct. They check the header field layout, the order of the payload slices, the length clamping at 0 and above the maximum, and that a message changed mid-packet does not leak into the flits.

// File: rtl/wms_pkg.sv
package wms_pkg;
  typedef enum logic [1:0] {
    FK_BODY = 2'd0,
    FK_HEAD = 2'd1,
    FK_TAIL = 2'd2
  } flit_kind_e;
endpackage

// File: rtl/wms_msg_reg.sv
module wms_msg_reg #(
  parameter int FLIT_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = 6,
  parameter int MAX_PAY = 4,
  localparam int LEN_W  = $clog2(MAX_PAY + 1),
  localparam int PAY_W  = MAX_PAY * FLIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ID_W-1:0]   in_id,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_dst,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [PAY_W-1:0]  in_payload,
  output logic [ID_W-1:0]   q_id,
  output logic [ADDR_W-1:0] q_src,
  output logic [ADDR_W-1:0] q_dst,
  output logic [LEN_W-1:0]  q_len,
  output logic [PAY_W-1:0]  q_payload
);
  // Effective payload count: at least one flit, at most MAX_PAY.
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req);
    if (req == '0)                    return LEN_W'(1);
    else if (req > LEN_W'(MAX_PAY))   return LEN_W'(MAX_PAY);
    else                              return req;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_id      <= '0;
      q_src     <= '0;
      q_dst     <= '0;
      q_len     <= LEN_W'(1);
      q_payload <= '0;
    end else if (take) begin
      q_id      <= in_id;
      q_src     <= in_src;
      q_dst     <= in_dst;
      q_len     <= clamp_len(in_len);
      q_payload <= in_payload;
    end
  end
endmodule

// File: rtl/wms_header_pack.sv
module wms_header_pack #(
  parameter int FLIT_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = 6,
  parameter int MAX_PAY = 4,
  localparam int LEN_W  = $clog2(MAX_PAY + 1)
) (
  input  logic [ID_W-1:0]   id,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [LEN_W-1:0]  len,
  output logic [FLIT_W-1:0] header
);
  localparam int SRC_LSB = ADDR_W;
  localparam int ID_LSB  = 2 * ADDR_W;
  localparam int LEN_LSB = ID_LSB + ID_W;

  // Fields placed from the low end upward; unused high bits are zero.
  function automatic logic [FLIT_W-1:0] build_header(
    input logic [ID_W-1:0] f_id, input logic [ADDR_W-1:0] f_src,
    input logic [ADDR_W-1:0] f_dst, input logic [LEN_W-1:0] f_len);
    logic [FLIT_W-1:0] h;
    h = '0;
    h[ADDR_W-1:0]              = f_dst;
    h[SRC_LSB +: ADDR_W]       = f_src;
    h[ID_LSB  +: ID_W]         = f_id;
    h[LEN_LSB +: LEN_W]        = f_len;
    return h;
  endfunction

  assign header = build_header(id, src, dst, len);
endmodule

// File: rtl/wms_payload_slicer.sv
module wms_payload_slicer #(
  parameter int FLIT_W  = 32,
  parameter int MAX_PAY = 4,
  localparam int LEN_W  = $clog2(MAX_PAY + 1),
  localparam int PAY_W  = MAX_PAY * FLIT_W
) (
  input  logic [PAY_W-1:0]  payload,
  input  logic [LEN_W-1:0]  idx,
  output logic [FLIT_W-1:0] word
);
  logic [FLIT_W-1:0] slices [MAX_PAY];

  for (genvar g = 0; g < MAX_PAY; g++) begin : g_slice
    assign slices[g] = payload[g*FLIT_W +: FLIT_W];
  end

  // Flit index 1 selects payload word 0, and so on.
  always_comb begin
    word = '0;
    for (int k = 0; k < MAX_PAY; k++) begin
      if (idx == LEN_W'(k + 1)) word = slices[k];
    end
  end
endmodule

// File: rtl/wms_flit_seq.sv
module wms_flit_seq
  import wms_pkg::*;
#(
  parameter int MAX_PAY = 4,
  localparam int LEN_W  = $clog2(MAX_PAY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             link_ready,
  input  logic [LEN_W-1:0] len_q,
  output logic             busy,
  output logic [LEN_W-1:0] idx,
  output logic             fire,
  output logic             last,
  output flit_kind_e       kind
);
  assign fire = busy && link_ready;
  assign last = busy && (idx == len_q);

  always_comb begin
    if (!busy)           kind = FK_BODY;
    else if (idx == '0)  kind = FK_HEAD;
    else if (last)       kind = FK_TAIL;
    else                 kind = FK_BODY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (fire) begin
      if (last) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx  <= idx + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/wide_msg_serializer.sv
module wide_msg_serializer
  import wms_pkg::*;
#(
  parameter int FLIT_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = 6,
  parameter int MAX_PAY = 4,
  localparam int LEN_W  = $clog2(MAX_PAY + 1),
  localparam int PAY_W  = MAX_PAY * FLIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [ID_W-1:0]   msg_id,
  input  logic [ADDR_W-1:0] msg_src,
  input  logic [ADDR_W-1:0] msg_dst,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic [PAY_W-1:0]  msg_payload,
  output logic              flit_valid,
  input  logic              flit_ready,
  output logic [FLIT_W-1:0] flit_data,
  output logic              flit_head,
  output logic              flit_tail
);
  // Named internal events, brought out for the checker.
  logic              take;
  logic              fire;
  logic              last;
  logic              busy;
  logic [LEN_W-1:0]  idx;
  flit_kind_e        kind;

  logic [ID_W-1:0]   q_id;
  logic [ADDR_W-1:0] q_src;
  logic [ADDR_W-1:0] q_dst;
  logic [LEN_W-1:0]  q_len;
  logic [PAY_W-1:0]  q_payload;
  logic [FLIT_W-1:0] hdr_word;
  logic [FLIT_W-1:0] pay_word;

  assign take = msg_valid && msg_ready;

  wms_msg_reg #(.FLIT_W(FLIT_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .MAX_PAY(MAX_PAY)) u_msg (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_id(msg_id), .in_src(msg_src), .in_dst(msg_dst),
    .in_len(msg_len), .in_payload(msg_payload),
    .q_id(q_id), .q_src(q_src), .q_dst(q_dst),
    .q_len(q_len), .q_payload(q_payload)
  );

  wms_flit_seq #(.MAX_PAY(MAX_PAY)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .link_ready(flit_ready),
    .len_q(q_len), .busy(busy), .idx(idx), .fire(fire),
    .last(last), .kind(kind)
  );

  wms_header_pack #(.FLIT_W(FLIT_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .MAX_PAY(MAX_PAY)) u_hdr (
    .id(q_id), .src(q_src), .dst(q_dst), .len(q_len), .header(hdr_word)
  );

  wms_payload_slicer #(.FLIT_W(FLIT_W), .MAX_PAY(MAX_PAY)) u_slc (
    .payload(q_payload), .idx(idx), .word(pay_word)
  );

  assign msg_ready  = !busy;
  assign flit_valid = busy;
  assign flit_head  = (kind == FK_HEAD);
  assign flit_tail  = (kind == FK_TAIL);
  assign flit_data  = (kind == FK_HEAD) ? hdr_word : pay_word;
endmodule

// File: rtl/wms_checker.sv
module wms_checker #(
  parameter int FLIT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_ready,
  input logic              flit_valid,
  input logic              flit_ready,
  input logic [FLIT_W-1:0] flit_data,
  input logic              flit_head,
  input logic              flit_tail,
  input logic              take,
  input logic              fire
);
  assert_type_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> !(flit_head && flit_tail));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !flit_ready) |=>
      (flit_valid && $stable(flit_data) && $stable(flit_head) && $stable(flit_tail)));

  assert_input_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> !msg_ready);

  assert_reopen_after_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && flit_tail) |=> msg_ready);

  assert_header_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (flit_valid && flit_head));

  assert_single_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && flit_head) |=> (flit_valid && !flit_head));

  assert_no_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !(fire && flit_tail)) |=> flit_valid);
endmodule

bind wide_msg_serializer wms_checker #(.FLIT_W(FLIT_W)) u_wms_chk (
  .clk(clk), .rst_n(rst_n), .msg_ready(msg_ready),
  .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data),
  .flit_head(flit_head), .flit_tail(flit_tail), .take(take), .fire(fire)
);

// File: tb/wide_msg_serializer_test.sv
module wide_msg_serializer_test;
  localparam int FLIT_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int ID_W    = 6;
  localparam int MAX_PAY = 4;
  localparam int LEN_W   = $clog2(MAX_PAY + 1);
  localparam int PAY_W   = MAX_PAY * FLIT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              msg_valid = 1'b0;
  logic              msg_ready;
  logic [ID_W-1:0]   msg_id = '0;
  logic [ADDR_W-1:0] msg_src = '0;
  logic [ADDR_W-1:0] msg_dst = '0;
  logic [LEN_W-1:0]  msg_len = '0;
  logic [PAY_W-1:0]  msg_payload = '0;
  logic              flit_valid;
  logic              flit_ready = 1'b0;
  logic [FLIT_W-1:0] flit_data;
  logic              flit_head;
  logic              flit_tail;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  wide_msg_serializer #(.FLIT_W(FLIT_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .MAX_PAY(MAX_PAY)) uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_id(msg_id), .msg_src(msg_src), .msg_dst(msg_dst), .msg_len(msg_len),
    .msg_payload(msg_payload), .flit_valid(flit_valid), .flit_ready(flit_ready),
    .flit_data(flit_data), .flit_head(flit_head), .flit_tail(flit_tail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [FLIT_W-1:0] act, input logic [FLIT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Header layout from R3: dst low, then src, id, effective count.
  function automatic logic [FLIT_W-1:0] exp_header(input int id, input int src,
                                                   input int dst, input int cnt);
    logic [FLIT_W-1:0] h;
    h = FLIT_W'(dst & 8'hFF);
    h = h | (FLIT_W'(src & 8'hFF) << 8);
    h = h | (FLIT_W'(id & 6'h3F) << 16);
    h = h | (FLIT_W'(cnt & 7) << 22);
    return h;
  endfunction

  // R9: effective payload count.
  function automatic int eff_count(input int req);
    if (req == 0) return 1;
    if (req > MAX_PAY) return MAX_PAY;
    return req;
  endfunction

  // stall_mode: 0 none, 1 every other cycle, 2 two stall cycles per flit.
  task automatic run_pkt(input int id, input int src, input int dst, input int len,
                         input logic [PAY_W-1:0] pay, input int stall_mode,
                         input bit garble, input string req);
    int cnt;
    int total;
    int k;
    int cyc;
    bit rdy;
    bit was_stalled;
    logic [FLIT_W-1:0] held_data;
    logic held_head;
    logic held_tail;
    logic [FLIT_W-1:0] exp_d;
    cnt = eff_count(len);
    total = cnt + 1;
    k = 0;
    cyc = 0;
    was_stalled = 1'b0;
    held_data = '0;
    held_head = 1'b0;
    held_tail = 1'b0;
    @(negedge clk);
    msg_id = ID_W'(id); msg_src = ADDR_W'(src); msg_dst = ADDR_W'(dst);
    msg_len = LEN_W'(len); msg_payload = pay; msg_valid = 1'b1;
    chk(msg_ready == 1'b1, "R2", "ready before offer", FLIT_W'(msg_ready), 1);
    while (k < total && cyc < 200) begin
      @(negedge clk);
      cyc++;
      chk(flit_valid && !msg_ready, "R11", {req, " valid held, input closed"},
          FLIT_W'({flit_valid, msg_ready}), FLIT_W'(2'b10));
      if (was_stalled) begin
        chk(flit_data == held_data && flit_head == held_head && flit_tail == held_tail,
            "R7", {req, " stalled flit held"}, flit_data, held_data);
      end
      case (stall_mode)
        0:       rdy = 1'b1;
        1:       rdy = (cyc % 2 == 0);
        default: rdy = (cyc % 3 == 0);
      endcase
      flit_ready = rdy;
      msg_valid = garble && !(k == total - 1 && rdy);
      if (garble) begin
        msg_id = ID_W'($urandom); msg_src = ADDR_W'($urandom);
        msg_dst = ADDR_W'($urandom); msg_len = LEN_W'($urandom);
        msg_payload = {$urandom, $urandom, $urandom, $urandom};
      end
      if (rdy) begin
        if (k == 0) begin
          exp_d = exp_header(id, src, dst, cnt);
          chk(flit_data == exp_d, garble ? "R10" : (len != cnt ? "R9" : "R3"),
              {req, " header data"}, flit_data, exp_d);
          chk(flit_head && !flit_tail, "R3", {req, " header type"},
              FLIT_W'({flit_head, flit_tail}), FLIT_W'(2'b10));
        end else begin
          exp_d = pay[(k-1)*FLIT_W +: FLIT_W];
          chk(flit_data == exp_d, garble ? "R10" : "R4", {req, " payload word"},
              flit_data, exp_d);
          chk(!flit_head && (flit_tail == (k == total - 1)),
              (total == 2) ? "R8" : "R5", {req, " payload type"},
              FLIT_W'({flit_head, flit_tail}), FLIT_W'({1'b0, (k == total - 1)}));
        end
        k++;
        was_stalled = 1'b0;
      end else begin
        was_stalled = 1'b1;
        held_data = flit_data; held_head = flit_head; held_tail = flit_tail;
      end
    end
    @(negedge clk);
    flit_ready = 1'b0;
    msg_valid = 1'b0;
    chk(k == total, "R5", {req, " flit count"}, FLIT_W'(k), FLIT_W'(total));
    chk(msg_ready && !flit_valid, garble ? "R10" : "R2", {req, " reopened, no new packet"},
        FLIT_W'({msg_ready, flit_valid}), FLIT_W'(2'b10));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!flit_valid && msg_ready, "R1", "in reset", FLIT_W'({flit_valid, msg_ready}), FLIT_W'(2'b01));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!flit_valid && msg_ready, "R1", "after reset", FLIT_W'({flit_valid, msg_ready}), FLIT_W'(2'b01));
  endtask

  task automatic t_three_words;
    run_pkt(5, 8'h12, 8'h34, 3, {32'h0, 32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001}, 0, 0, "len3");
  endtask

  task automatic t_single_word;
    run_pkt(9, 8'h01, 8'hF0, 1, {96'h0, 32'h1234_5678}, 0, 0, "single");
  endtask

  task automatic t_full_stalled;
    run_pkt(63, 8'hFF, 8'h80, 4, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}, 1, 0, "full alt-stall");
    run_pkt(17, 8'h5A, 8'hA5, 2, {64'h0, 32'hDEAD_BEEF, 32'hCAFE_F00D}, 2, 0, "len2 long-stall");
  endtask

  task automatic t_len_zero;
    run_pkt(3, 8'h22, 8'h33, 0, {96'h0, 32'h0BAD_CAFE}, 0, 0, "len0");
  endtask

  task automatic t_len_over;
    run_pkt(44, 8'h77, 8'h66, 7, {32'h9999_0004, 32'h9999_0003, 32'h9999_0002, 32'h9999_0001}, 0, 0, "len7");
  endtask

  task automatic t_busy_ignore;
    run_pkt(21, 8'h10, 8'h20, 3, {32'h0, 32'h0303_0303, 32'h0202_0202, 32'h0101_0101}, 1, 1, "garbled inputs");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_three_words();
    t_single_word();
    t_full_stalled();
    t_len_zero();
    t_len_over();
    t_busy_ignore();
    t_three_words();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule